// File: doc/BRIEF.md
# Dual-Clock Almost-Empty / Almost-Full Flag Generator

This block produces the two early-warning status flags of a dual-clock FIFO. Its inputs are the binary write pointer, which belongs to the write clock, and the binary read pointer, which belongs to the read clock. It also takes two offsets that set the thresholds. It drives an active-low almost-empty flag and an active-low almost-full flag. Each pointer crosses into the other clock domain as Gray code. There it passes through a chain of flip-flops. Each domain then works out the fill level from its own pointer and the other domain's delayed pointer.

While master reset is held, the block samples a mode input, and the mode stays fixed until the next master reset. In synchronous mode, each flag is a plain register in one clock domain: almost-empty in the read domain, almost-full in the write domain. In split mode, each flag is asserted by an edge of one clock and released by an edge of the other clock. The assert side and the release side pass a toggle token between them, so that assertions and releases strictly alternate.

The FIFO depth must be a power of two. The offsets are treated as quasi-static: change them only while reset is held. Each pointer moves by at most one per edge of its own clock. The write pointer never runs more than the depth ahead of the read pointer.

Top module: `dcf_almost_flags`

## Requirements
- R1: While `mrst_n` is low, `pae_n` is 0 (active) and `paf_n` is 1 (inactive).
- R2: `sync_mode_in` is captured on every clock edge while `mrst_n` is low. A value of 1 selects synchronous mode and 0 selects split mode. Changes after reset is released have no effect on either flag.
- R3: Synchronous mode, almost-empty flag. On each read-clock edge, `pae_n` is loaded with 0 when the read-side fill is at or below `empty_ofs`, and with 1 otherwise. The read-side fill is the write pointer delayed by one write-clock register and SYNC_STAGES read-clock flops, minus `rd_ptr`. The flag never changes on a write-clock edge.
- R4: Synchronous mode, almost-full flag. On each write-clock edge, `paf_n` is loaded with 0 when the write-side free space is at or below `full_ofs`, and with 1 otherwise. Free space is DEPTH minus (`wr_ptr` minus the read pointer delayed by one read-clock register and SYNC_STAGES write-clock flops). The flag never changes on a read-clock edge.
- R5: Split mode, almost-full set. `paf_n` falls on a write-clock edge when the write-side free space is at or below `full_ofs` and the last release is already visible on the write side.
- R6: Split mode, almost-full release. `paf_n` rises on a read-clock edge when the read-side free space is above `full_ofs` and the last assertion is already visible on the read side.
- R7: Split mode, almost-empty. `pae_n` falls on a read-clock edge when the read-side fill is at or below `empty_ofs`, and rises on a write-clock edge when the write-side fill is above `empty_ofs`. Each event waits until the other side can see the previous event.
- R8: In split mode, an assert or release event becomes visible to the other side after SYNC_STAGES+1 flops. This is one flop more than the pointers take, so a flag is never re-armed from a stale pointer.
- R9: The pointers are PW = log2(DEPTH)+1 bits wide and wrap modulo 2·DEPTH. Once both pointers have been still long enough for every flop chain to settle, and in either mode, `pae_n` = 0 exactly when fill ≤ `empty_ofs`, and `paf_n` = 0 exactly when DEPTH−fill ≤ `full_ofs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| sync_mode_in | input | 1 | Flag timing mode, sampled during reset (1 = synchronous, 0 = split) |
| wr_ptr | input | PW | Binary write pointer, write-clock domain |
| rd_ptr | input | PW | Binary read pointer, read-clock domain |
| empty_ofs | input | PW-1 | Almost-empty threshold |
| full_ofs | input | PW-1 | Almost-full threshold |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
The two clocks run at unrelated periods, and their edges are placed so that they never coincide. A pointer change reaches the opposite domain after one source edge plus SYNC_STAGES destination edges. A synchronous flag follows its condition one edge of its own clock later. A split-mode token is seen on the far side after SYNC_STAGES+1 edges. The bench steps a behavioural model on every rising edge of each clock and compares both flags on every falling edge of either clock. It does this in each mode and across pointer wrap, and each run ends with a settled-level check against the true fill.

// File: rtl/afg_pkg.sv
`timescale 1ns/1ps
package afg_pkg;
  typedef enum logic {
    FM_SPLIT = 1'b0,
    FM_SYNC  = 1'b1
  } flag_mode_e;

  typedef struct packed {
    logic empty_hit;
    logic full_hit;
  } level_hits_t;
endpackage

// File: rtl/afg_bit_sync.sv
`timescale 1ns/1ps
module afg_bit_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = W * STAGES;

  logic [CW-1:0] chain;

  // flop chain into the destination domain; the newest value enters at the bottom
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {CW{RST_BIT}};
    else        chain <= {chain[CW-W-1:0], d};
  end

  assign q = chain[CW-1 -: W];
endmodule

// File: rtl/afg_ptr_cross.sv
`timescale 1ns/1ps
module afg_ptr_cross #(
  parameter int PW     = 10,
  parameter int STAGES = 2
) (
  input  logic          src_clk,
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] src_bin,
  output logic [PW-1:0] dst_bin
);
  logic [PW-1:0] gray_src;
  logic [PW-1:0] gray_dst;

  // registered Gray copy in the source domain, so only one bit moves per step
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) gray_src <= '0;
    else        gray_src <= src_bin ^ (src_bin >> 1);
  end

  afg_bit_sync #(.W(PW), .STAGES(STAGES), .RST_BIT(1'b0)) u_sync (
    .clk   (dst_clk),
    .rst_n (rst_n),
    .d     (gray_src),
    .q     (gray_dst)
  );

  always_comb begin
    for (int i = 0; i < PW; i++) dst_bin[i] = ^(gray_dst >> i);
  end
endmodule

// File: rtl/afg_level.sv
`timescale 1ns/1ps
module afg_level #(
  parameter int DEPTH  = 512,
  parameter int AW     = 9,
  parameter int PW     = 10,
  parameter bit WRITER = 1'b1
) (
  input  logic [PW-1:0]       local_ptr,
  input  logic [PW-1:0]       remote_ptr,
  input  logic [AW-1:0]       empty_ofs,
  input  logic [AW-1:0]       full_ofs,
  output afg_pkg::level_hits_t hits
);
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  logic [PW-1:0] fill;
  logic [PW-1:0] room;

  if (WRITER) begin : g_wside
    assign fill = local_ptr - remote_ptr;
  end else begin : g_rside
    assign fill = remote_ptr - local_ptr;
  end

  assign room           = DEPTH_V - fill;
  assign hits.empty_hit = fill <= PW'(empty_ofs);
  assign hits.full_hit  = room <= PW'(full_ofs);
endmodule

// File: rtl/afg_flag_unit.sv
`timescale 1ns/1ps
module afg_flag_unit #(
  parameter int   TOK_STAGES = 3,
  parameter logic SET_RST    = 1'b0,
  parameter logic SYNC_RST   = 1'b1
) (
  input  logic set_clk,
  input  logic clr_clk,
  input  logic rst_n,
  input  logic hit_set,
  input  logic hit_clr,
  output logic sync_flag_n,
  output logic set_tog,
  output logic clr_tog
);
  logic clr_seen;
  logic set_seen;

  // owner-domain register for synchronous mode, and the set half of the token pair
  always_ff @(posedge set_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_flag_n <= SYNC_RST;
      set_tog     <= SET_RST;
    end else begin
      sync_flag_n <= ~hit_set;
      if (hit_set && (set_tog == clr_seen)) set_tog <= ~set_tog;
    end
  end

  // release half of the token pair in the other domain
  always_ff @(posedge clr_clk or negedge rst_n) begin
    if (!rst_n) clr_tog <= 1'b0;
    else if (!hit_clr && (set_seen != clr_tog)) clr_tog <= ~clr_tog;
  end

  afg_bit_sync #(.W(1), .STAGES(TOK_STAGES), .RST_BIT(1'b0)) u_clr2set (
    .clk   (set_clk),
    .rst_n (rst_n),
    .d     (clr_tog),
    .q     (clr_seen)
  );

  afg_bit_sync #(.W(1), .STAGES(TOK_STAGES), .RST_BIT(SET_RST)) u_set2clr (
    .clk   (clr_clk),
    .rst_n (rst_n),
    .d     (set_tog),
    .q     (set_seen)
  );
endmodule

// File: rtl/dcf_almost_flags.sv
`timescale 1ns/1ps
module dcf_almost_flags #(
  parameter int DEPTH       = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       wclk,
  input  logic                       rclk,
  input  logic                       mrst_n,
  input  logic                       sync_mode_in,
  input  logic [$clog2(DEPTH):0]     wr_ptr,
  input  logic [$clog2(DEPTH):0]     rd_ptr,
  input  logic [$clog2(DEPTH)-1:0]   empty_ofs,
  input  logic [$clog2(DEPTH)-1:0]   full_ofs,
  output logic                       pae_n,
  output logic                       paf_n
);
  import afg_pkg::*;

  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int TOK = SYNC_STAGES + 1;

  flag_mode_e  mode_w, mode_r;
  logic [PW-1:0] rptr_w, wptr_r;
  level_hits_t hits_w, hits_r;
  logic full_hit_w, empty_hit_w, full_hit_r, empty_hit_r;
  logic pae_sync_n, pae_set_tog, pae_clr_tog;
  logic paf_sync_n, paf_set_tog, paf_clr_tog;

  // mode copies, one per domain, loaded only while master reset is held
  always_ff @(posedge wclk) begin
    if (!mrst_n) mode_w <= flag_mode_e'(sync_mode_in);
  end

  always_ff @(posedge rclk) begin
    if (!mrst_n) mode_r <= flag_mode_e'(sync_mode_in);
  end

  afg_ptr_cross #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .src_clk (wclk), .dst_clk (rclk), .rst_n (mrst_n),
    .src_bin (wr_ptr), .dst_bin (wptr_r)
  );

  afg_ptr_cross #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .src_clk (rclk), .dst_clk (wclk), .rst_n (mrst_n),
    .src_bin (rd_ptr), .dst_bin (rptr_w)
  );

  afg_level #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .WRITER(1'b1)) u_lvl_w (
    .local_ptr (wr_ptr), .remote_ptr (rptr_w),
    .empty_ofs (empty_ofs), .full_ofs (full_ofs), .hits (hits_w)
  );

  afg_level #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .WRITER(1'b0)) u_lvl_r (
    .local_ptr (rd_ptr), .remote_ptr (wptr_r),
    .empty_ofs (empty_ofs), .full_ofs (full_ofs), .hits (hits_r)
  );

  assign full_hit_w  = hits_w.full_hit;
  assign empty_hit_w = hits_w.empty_hit;
  assign full_hit_r  = hits_r.full_hit;
  assign empty_hit_r = hits_r.empty_hit;

  // almost-empty: owned and asserted by the read clock, released by the write clock
  afg_flag_unit #(.TOK_STAGES(TOK), .SET_RST(1'b1), .SYNC_RST(1'b0)) u_pae (
    .set_clk (rclk), .clr_clk (wclk), .rst_n (mrst_n),
    .hit_set (empty_hit_r), .hit_clr (empty_hit_w),
    .sync_flag_n (pae_sync_n), .set_tog (pae_set_tog), .clr_tog (pae_clr_tog)
  );

  // almost-full: owned and asserted by the write clock, released by the read clock
  afg_flag_unit #(.TOK_STAGES(TOK), .SET_RST(1'b0), .SYNC_RST(1'b1)) u_paf (
    .set_clk (wclk), .clr_clk (rclk), .rst_n (mrst_n),
    .hit_set (full_hit_w), .hit_clr (full_hit_r),
    .sync_flag_n (paf_sync_n), .set_tog (paf_set_tog), .clr_tog (paf_clr_tog)
  );

  assign pae_n = (mode_r == FM_SYNC) ? pae_sync_n : ~(pae_set_tog ^ pae_clr_tog);
  assign paf_n = (mode_w == FM_SYNC) ? paf_sync_n : ~(paf_set_tog ^ paf_clr_tog);
endmodule

// File: rtl/afg_checker.sv
`timescale 1ns/1ps
module afg_checker #(
  parameter int PW = 10
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          mode_w,
  input logic          mode_r,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          pae_n,
  input logic          paf_n,
  input logic          full_hit_w,
  input logic          full_hit_r,
  input logic          empty_hit_r,
  input logic          paf_set_tog,
  input logic          paf_clr_tog
);
  always @(posedge wclk) begin
    if (!mrst_n && !$isunknown(mode_w) && !$isunknown(mode_r))
      AST_RESET_FLAGS: assert (pae_n == 1'b0 && paf_n == 1'b1); // R1
  end

  AST_MODE_FIXED: assert property (@(posedge wclk) disable iff (!mrst_n) $stable(mode_w)); // R2

  AST_SYNC_PAE: assert property (@(posedge rclk) disable iff (!mrst_n) mode_r |=> (pae_n == !$past(empty_hit_r))); // R3

  AST_SYNC_PAF: assert property (@(posedge wclk) disable iff (!mrst_n) mode_w |=> (paf_n == !$past(full_hit_w))); // R4

  AST_SPLIT_PAF_SET: assert property (@(posedge wclk) disable iff (!mrst_n) (!mode_w && !$stable(paf_set_tog)) |-> $past(full_hit_w)); // R5

  AST_SPLIT_PAF_CLR: assert property (@(posedge rclk) disable iff (!mrst_n) (!mode_r && !$stable(paf_clr_tog)) |-> !$past(full_hit_r)); // R6

  AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (!mrst_n) PW'(wr_ptr - $past(wr_ptr)) <= PW'(1)); // R9

  AST_RPTR_STEP: assert property (@(posedge rclk) disable iff (!mrst_n) PW'(rd_ptr - $past(rd_ptr)) <= PW'(1)); // R9
endmodule

bind dcf_almost_flags afg_checker #(.PW(PW)) u_chk (
  .wclk        (wclk),
  .rclk        (rclk),
  .mrst_n      (mrst_n),
  .mode_w      (mode_w),
  .mode_r      (mode_r),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .pae_n       (pae_n),
  .paf_n       (paf_n),
  .full_hit_w  (full_hit_w),
  .full_hit_r  (full_hit_r),
  .empty_hit_r (empty_hit_r),
  .paf_set_tog (paf_set_tog),
  .paf_clr_tog (paf_clr_tog)
);

// File: tb/dcf_almost_flags_test.sv
`timescale 1ns/1ps
module dcf_almost_flags_test;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int PW    = 5;
  localparam int MOD   = 2 * DEPTH;

  logic wclk = 1'b0, rclk = 1'b0, mrst_n = 1'b0, mode_in = 1'b1;
  logic [AW-1:0] eofs = '0, fofs = '0;
  int wp = 0, rp = 0;
  int w_pct = 0, r_pct = 0;
  bit w_go = 0, r_go = 0, armed = 0, done = 0;
  int n_chk = 0, n_bad = 0;
  logic pae_n, paf_n;
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign wr_ptr = PW'(wp);
  assign rd_ptr = PW'(rp);

  always #10 wclk = ~wclk;
  initial begin
    #7 rclk = 1'b1;
    forever #15 rclk = ~rclk;
  end

  dcf_almost_flags #(.DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
    .wclk (wclk), .rclk (rclk), .mrst_n (mrst_n), .sync_mode_in (mode_in),
    .wr_ptr (wr_ptr), .rd_ptr (rd_ptr), .empty_ofs (eofs), .full_ofs (fofs),
    .pae_n (pae_n), .paf_n (paf_n)
  );

  // behavioural reference: delayed views of each pointer and the two token pairs
  logic m_mode_w, m_mode_r;
  int   m_wg, m_rg;
  int   m_rs[2], m_ws[2];
  logic m_paf_q, m_pae_q, m_sf, m_cf, m_se, m_ce;
  logic [2:0] m_cfw, m_sew, m_cer, m_sfr;

  always @(posedge wclk) if (!mrst_n) m_mode_w <= mode_in;
  always @(posedge rclk) if (!mrst_n) m_mode_r <= mode_in;

  always @(posedge wclk or negedge mrst_n) begin
    int fw;
    if (!mrst_n) begin
      m_wg <= 0; m_rs[0] <= 0; m_rs[1] <= 0;
      m_paf_q <= 1'b1; m_sf <= 1'b0; m_ce <= 1'b0;
      m_cfw <= 3'b000; m_sew <= 3'b111;
    end else begin
      fw = (wp - m_rs[1] + MOD) % MOD;
      m_wg <= wp;
      m_rs[0] <= m_rg;
      m_rs[1] <= m_rs[0];
      m_paf_q <= !((DEPTH - fw) <= int'(fofs));
      if (((DEPTH - fw) <= int'(fofs)) && (m_sf == m_cfw[2])) m_sf <= !m_sf;
      m_cfw <= {m_cfw[1:0], m_cf};
      if (!(fw <= int'(eofs)) && (m_sew[2] != m_ce)) m_ce <= !m_ce;
      m_sew <= {m_sew[1:0], m_se};
    end
  end

  always @(posedge rclk or negedge mrst_n) begin
    int fr;
    if (!mrst_n) begin
      m_rg <= 0; m_ws[0] <= 0; m_ws[1] <= 0;
      m_pae_q <= 1'b0; m_se <= 1'b1; m_cf <= 1'b0;
      m_cer <= 3'b000; m_sfr <= 3'b000;
    end else begin
      fr = (m_ws[1] - rp + MOD) % MOD;
      m_rg <= rp;
      m_ws[0] <= m_wg;
      m_ws[1] <= m_ws[0];
      m_pae_q <= !(fr <= int'(eofs));
      if ((fr <= int'(eofs)) && (m_se == m_cer[2])) m_se <= !m_se;
      m_cer <= {m_cer[1:0], m_ce};
      if (!((DEPTH - fr) <= int'(fofs)) && (m_sfr[2] != m_cf)) m_cf <= !m_cf;
      m_sfr <= {m_sfr[1:0], m_sf};
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic e_pae, e_paf;
    e_pae = m_mode_r ? m_pae_q : !(m_se ^ m_ce);
    e_paf = m_mode_w ? m_paf_q : !(m_sf ^ m_cf);
    if (m_mode_r) chk("R2/R3 sync almost-empty", pae_n, e_pae);
    else          chk("R2/R7 split almost-empty", pae_n, e_pae);
    if (m_mode_w) chk("R2/R4 sync almost-full", paf_n, e_paf);
    else          chk("R2/R5/R6/R8 split almost-full", paf_n, e_paf);
  endtask

  always @(negedge wclk) if (mrst_n && armed) compare_all();
  always @(negedge rclk) if (mrst_n && armed) compare_all();

  // writer is held back by its own delayed view of the read pointer, reader likewise
  initial forever begin
    @(negedge wclk);
    if (w_go && ((wp - m_rs[1] + MOD) % MOD) < DEPTH && int'($urandom % 100) < w_pct)
      wp = (wp + 1) % MOD;
  end

  initial forever begin
    @(negedge rclk);
    if (r_go && ((m_ws[1] - rp + MOD) % MOD) > 0 && int'($urandom % 100) < r_pct)
      rp = (rp + 1) % MOD;
  end

  task automatic settle();
    int f;
    w_go = 0; r_go = 0;
    repeat (20) @(negedge rclk);
    @(negedge wclk);
    f = (wp - rp + MOD) % MOD;
    chk("R9 settled almost-empty", pae_n, !(f <= int'(eofs)));
    chk("R9 settled almost-full", paf_n, !((DEPTH - f) <= int'(fofs)));
  endtask

  task automatic traffic(input int wpct, input int rpct, input int cycles);
    w_pct = wpct; r_pct = rpct; w_go = 1; r_go = 1;
    repeat (cycles) @(negedge wclk);
    settle();
  endtask

  task automatic run(input logic mode, input int e, input int f);
    w_go = 0; r_go = 0;
    @(negedge wclk); #3;
    mrst_n = 1'b0; mode_in = mode; eofs = AW'(e); fofs = AW'(f); wp = 0; rp = 0;
    repeat (6) @(negedge rclk);
    @(negedge wclk);
    chk("R1 reset almost-empty", pae_n, 1'b0);
    chk("R1 reset almost-full", paf_n, 1'b1);
    @(negedge wclk); #3;
    mrst_n = 1'b1; armed = 1;
    repeat (3) @(negedge wclk);
    mode_in = !mode;            // R2: must be ignored after release
    traffic(100, 0, 80);        // fill up to full
    traffic(0, 100, 80);        // drain to empty
    traffic(55, 80, 1200);      // mixed, wraps pointers (R9)
    traffic(90, 40, 300);       // writer-heavy
    traffic(30, 100, 300);      // reader-heavy
  endtask

  initial begin
    run(1'b1, 3, 4);
    run(1'b0, 3, 4);
    run(1'b1, 0, 15);
    run(1'b0, 15, 0);
    run(1'b0, 7, 7);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished at %0t", $time);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule